// File: doc/BRIEF.md
# Program Status Poll Responder

This block forms the byte a host sees when it reads the memory device. While the program/erase engine is idle, array read data passes straight through. While the engine is busy with an internal program or erase cycle, the read returns a status byte instead. It carries two independent end-of-operation indicators. One bit position carries the complement of the expected final value of the last loaded byte. Another bit position flips once for every completed host read.

The host polls by reading repeatedly. The complemented bit turns back into true data once the engine finishes. The flipping bit stops flipping at the same moment. Bus gating is modelled as a drive indication: data is presented only while both active-low enables are asserted, and the output word is forced to zero otherwise.

Top module: `poll_status_responder`

## Requirements
- R1: `dq_drive` is 1 exactly when `ce_n` and `oe_n` are both 0, in the same cycle and with no register on the path.
- R2: When `dq_drive` is 0, `dq_out` is all zeros.
- R3: While `eng_busy` is 0 and a read is active, `dq_out` equals `arr_rdata` in the same cycle.
- R4: During a program busy period (`eng_busy`=1, `eng_erase`=0), bit 7 of `dq_out` is the inverse of `ld_poll_bit` as captured at the most recent clock edge where `ld_stb` was 1.
- R5: During an erase busy period (`eng_busy`=1, `eng_erase`=1), bit 7 of `dq_out` is 0, the inverse of bit 7 of the erased value FFh.
- R6: During busy, bit 6 of `dq_out` shows a toggle register. The register inverts at each clock edge where a read was active in the previous cycle and is not active now, with `eng_busy` high. It is unchanged otherwise.
- R7: At the clock edge where `eng_busy` is first seen high after being low, the toggle register is cleared to 0, taking priority over an inversion. The first read of each busy period therefore sees bit 6 = 0.
- R8: During busy, bits 5 to 0 of `dq_out` are 0.
- R9: In the first cycle after `eng_busy` falls, an active read returns the true array data on all bits.
- R10: Synchronous reset `rst` clears the toggle register and the captured poll bit to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eng_busy | input | 1 | Program/erase engine running an internal cycle |
| eng_erase | input | 1 | Current busy period is a chip erase |
| ld_stb | input | 1 | Byte-load strobe from the page loader |
| ld_poll_bit | input | 1 | Bit 7 of the byte being loaded |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| arr_rdata | input | 8 | Array read data |
| dq_out | output | 8 | Read data word |
| dq_drive | output | 1 | Data bus driven (else high impedance) |

## Verification
The drive indication, the pass-through data and the placement of the status bits are combinational. They are due in the same cycle as the enables, the busy flag and the array data that produce them. The captured poll bit and the toggle register each sit one register from their causes. A load strobe, a read end or a busy rise takes effect in the cycle after the edge that samples it. The bench changes inputs on the falling edge and compares outputs with its model halfway through the low phase. The model updates its own state on the rising edge, so every comparison sees exactly one edge between cause and effect.

// File: rtl/poll_pkg.sv
package poll_pkg;

    localparam int unsigned DEF_DATA_W   = 8;
    localparam int unsigned DEF_POLL_BIT = 7;
    localparam int unsigned DEF_TOG_BIT  = 6;

    typedef enum logic [1:0] {
        SRC_HIZ    = 2'd0,
        SRC_ARRAY  = 2'd1,
        SRC_STATUS = 2'd2
    } rd_src_e;

    typedef struct packed {
        logic poll;
        logic tog;
    } status_bits_t;

    function automatic rd_src_e pick_source(input logic reading, input logic busy);
        if (!reading)
            return SRC_HIZ;
        else if (busy)
            return SRC_STATUS;
        else
            return SRC_ARRAY;
    endfunction

    function automatic logic poll_value(input logic erase, input logic erase_fill_bit,
                                        input logic loaded_bit);
        return erase ? ~erase_fill_bit : ~loaded_bit;
    endfunction

endpackage

// File: rtl/poll_read_track.sv
module poll_read_track (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    input  logic oe_n,
    output logic rd_on,
    output logic rd_done
);
    logic rd_q;

    assign rd_on   = ~ce_n & ~oe_n;
    assign rd_done = rd_q & ~rd_on;

    always_ff @(posedge clk) begin
        if (rst)
            rd_q <= 1'b0;
        else
            rd_q <= rd_on;
    end
endmodule

// File: rtl/poll_toggle.sv
module poll_toggle #(
    parameter logic TOG_INIT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic rd_done,
    output logic tog
);
    logic busy_q;
    logic busy_rise;

    assign busy_rise = busy & ~busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            tog    <= TOG_INIT;
        end else begin
            busy_q <= busy;
            if (busy_rise)
                tog <= TOG_INIT;
            else if (busy && rd_done)
                tog <= ~tog;
        end
    end
endmodule

// File: rtl/poll_last_bit.sv
module poll_last_bit (
    input  logic clk,
    input  logic rst,
    input  logic ld_stb,
    input  logic ld_bit,
    output logic last_bit
);
    always_ff @(posedge clk) begin
        if (rst)
            last_bit <= 1'b0;
        else if (ld_stb)
            last_bit <= ld_bit;
    end
endmodule

// File: rtl/poll_out_mux.sv
module poll_out_mux
    import poll_pkg::*;
#(
    parameter int unsigned DATA_W   = DEF_DATA_W,
    parameter int unsigned POLL_BIT = DEF_POLL_BIT,
    parameter int unsigned TOG_BIT  = DEF_TOG_BIT
) (
    input  rd_src_e            src,
    input  status_bits_t       stat,
    input  logic [DATA_W-1:0]  arr_rdata,
    output logic [DATA_W-1:0]  dq_out
);
    logic [DATA_W-1:0] status_word;

    for (genvar i = 0; i < DATA_W; i++) begin : g_stat
        if (i == POLL_BIT) begin : g_poll
            assign status_word[i] = stat.poll;
        end else if (i == TOG_BIT) begin : g_tog
            assign status_word[i] = stat.tog;
        end else begin : g_zero
            assign status_word[i] = 1'b0;
        end
    end

    always_comb begin
        unique case (src)
            SRC_ARRAY:  dq_out = arr_rdata;
            SRC_STATUS: dq_out = status_word;
            default:    dq_out = '0;
        endcase
    end
endmodule

// File: rtl/poll_status_responder.sv
module poll_status_responder
    import poll_pkg::*;
#(
    parameter int unsigned DATA_W         = DEF_DATA_W,
    parameter int unsigned POLL_BIT       = DEF_POLL_BIT,
    parameter int unsigned TOG_BIT        = DEF_TOG_BIT,
    parameter logic        ERASE_FILL_BIT = 1'b1,
    parameter logic        TOG_INIT       = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              eng_busy,
    input  logic              eng_erase,
    input  logic              ld_stb,
    input  logic              ld_poll_bit,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_drive
);
    localparam bit BITS_OK = (POLL_BIT < DATA_W) && (TOG_BIT < DATA_W) && (POLL_BIT != TOG_BIT);

    if (!BITS_OK) begin : g_bad_bits
        initial $error("status bit positions invalid");
    end

    logic         rd_on;
    logic         rd_done;
    logic         tog;
    logic         last_bit;
    rd_src_e      src;
    status_bits_t stat;

    poll_read_track u_track (
        .clk     (clk),
        .rst     (rst),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .rd_on   (rd_on),
        .rd_done (rd_done)
    );

    poll_toggle #(.TOG_INIT(TOG_INIT)) u_tog (
        .clk     (clk),
        .rst     (rst),
        .busy    (eng_busy),
        .rd_done (rd_done),
        .tog     (tog)
    );

    poll_last_bit u_last (
        .clk      (clk),
        .rst      (rst),
        .ld_stb   (ld_stb),
        .ld_bit   (ld_poll_bit),
        .last_bit (last_bit)
    );

    always_comb begin
        src       = pick_source(rd_on, eng_busy);
        stat.poll = poll_value(eng_erase, ERASE_FILL_BIT, last_bit);
        stat.tog  = tog;
    end

    poll_out_mux #(
        .DATA_W   (DATA_W),
        .POLL_BIT (POLL_BIT),
        .TOG_BIT  (TOG_BIT)
    ) u_mux (
        .src       (src),
        .stat      (stat),
        .arr_rdata (arr_rdata),
        .dq_out    (dq_out)
    );

    assign dq_drive = (src != SRC_HIZ);
endmodule

// File: rtl/poll_status_chk.sv
module poll_status_chk #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned POLL_BIT = 7,
    parameter int unsigned TOG_BIT  = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              eng_busy,
    input logic              eng_erase,
    input logic              ce_n,
    input logic              oe_n,
    input logic [DATA_W-1:0] arr_rdata,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_drive
);
    localparam logic [DATA_W-1:0] STAT_MASK = (DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TOG_BIT);

    a_r1_drive_follows_enables: assert property (@(posedge clk) disable iff (rst)
        dq_drive == (!ce_n && !oe_n));

    a_r2_idle_bus_zero: assert property (@(posedge clk) disable iff (rst)
        !dq_drive |-> dq_out == '0);

    a_r3_passthrough: assert property (@(posedge clk) disable iff (rst)
        (!eng_busy && dq_drive) |-> dq_out == arr_rdata);

    a_r5_erase_poll_low: assert property (@(posedge clk) disable iff (rst)
        (eng_busy && eng_erase && dq_drive) |-> !dq_out[POLL_BIT]);

    a_r6_toggle_held_in_read: assert property (@(posedge clk) disable iff (rst)
        (eng_busy && $past(eng_busy) && $past(eng_busy, 2) && dq_drive && $past(dq_drive))
        |-> $stable(dq_out[TOG_BIT]));

    a_r7_toggle_starts_low: assert property (@(posedge clk) disable iff (rst)
        $rose(eng_busy) |=> (!(eng_busy && dq_drive) || !dq_out[TOG_BIT]));

    a_r8_other_bits_zero: assert property (@(posedge clk) disable iff (rst)
        (eng_busy && dq_drive) |-> (dq_out & ~STAT_MASK) == '0);
endmodule

bind poll_status_responder poll_status_chk #(
    .DATA_W   (DATA_W),
    .POLL_BIT (POLL_BIT),
    .TOG_BIT  (TOG_BIT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .eng_busy  (eng_busy),
    .eng_erase (eng_erase),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .arr_rdata (arr_rdata),
    .dq_out    (dq_out),
    .dq_drive  (dq_drive)
);

// File: tb/sim_poll_status_responder.sv
`timescale 1ns/1ps
module sim_poll_status_responder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       eng_busy = 1'b0;
    logic       eng_erase = 1'b0;
    logic       ld_stb = 1'b0;
    logic       ld_poll_bit = 1'b0;
    logic       ce_n = 1'b1;
    logic       oe_n = 1'b1;
    logic [7:0] arr_rdata = 8'h00;
    logic [7:0] dq_out;
    logic       dq_drive;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    poll_status_responder u0 (
        .clk(clk), .rst(rst), .eng_busy(eng_busy), .eng_erase(eng_erase),
        .ld_stb(ld_stb), .ld_poll_bit(ld_poll_bit), .ce_n(ce_n), .oe_n(oe_n),
        .arr_rdata(arr_rdata), .dq_out(dq_out), .dq_drive(dq_drive)
    );

    // behavioural reference state
    bit m_tog, m_last, m_rd_prev, m_busy_prev;
    bit m_busy_fell;
    wire rd_now = !ce_n && !oe_n;

    always @(posedge clk) begin
        if (rst) begin
            m_tog <= 0; m_last <= 0; m_rd_prev <= 0; m_busy_prev <= 0; m_busy_fell <= 0;
        end else begin
            m_rd_prev   <= rd_now;
            m_busy_prev <= eng_busy;
            m_busy_fell <= m_busy_prev && !eng_busy;
            if (ld_stb) m_last <= ld_poll_bit;
            if (eng_busy && !m_busy_prev) m_tog <= 0;
            else if (eng_busy && m_rd_prev && !rd_now) m_tog <= !m_tog;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #5;
        if (!finished) begin
            check("R1 drive", dq_drive, rd_now);
            if (!rd_now) check("R2 zero bus", dq_out, 0);
            else if (!eng_busy) begin
                if (m_busy_fell) check("R9 true data after busy", dq_out, arr_rdata);
                else             check("R3 pass-through", dq_out, arr_rdata);
            end else begin
                if (eng_erase) check("R5 erase poll", dq_out[7], 0);
                else           check("R4 program poll", dq_out[7], !m_last);
                check("R6/R7 toggle", dq_out[6], m_tog);
                check("R8 low bits", dq_out[5:0], 0);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_read(input logic [7:0] d, input int len);
        @(negedge clk); ce_n = 0; oe_n = 0; arr_rdata = d;
        cyc(len - 1);
        @(negedge clk); ce_n = 1; oe_n = 1;
    endtask

    task automatic load(input logic b);
        @(negedge clk); ld_stb = 1; ld_poll_bit = b;
        @(negedge clk); ld_stb = 0; ld_poll_bit = !b;
    endtask

    initial begin
        cyc(3);
        rst = 0;
        // R10: state after reset, first busy read sees poll=~0, toggle 0
        @(negedge clk); eng_busy = 1;
        host_read(8'h00, 1);
        host_read(8'h00, 2);
        @(negedge clk); eng_busy = 0;
        // R1/R2: single enables
        @(negedge clk); ce_n = 0; oe_n = 1; arr_rdata = 8'h5A;
        @(negedge clk); ce_n = 1; oe_n = 0;
        @(negedge clk); oe_n = 1;
        // R3: idle pass-through with varied data
        host_read(8'hA5, 1);
        host_read(8'hFF, 3);
        host_read(8'h3C, 2);
        // R4/R6: program busy after loading bit 1
        load(1'b0); load(1'b1);
        @(negedge clk); eng_busy = 1; eng_erase = 0;
        for (int k = 0; k < 5; k++) begin
            host_read(8'h77, 1 + (k % 3));
            cyc(k % 2);
        end
        // back-to-back reads with no gap: toggle inverts only on read end
        @(negedge clk); ce_n = 0; oe_n = 0;
        @(negedge clk); oe_n = 1;
        @(negedge clk); oe_n = 0;
        @(negedge clk); ce_n = 1;
        @(negedge clk); ce_n = 0;
        // R9: busy falls while reading
        @(negedge clk); eng_busy = 0; arr_rdata = 8'h81;
        @(negedge clk); arr_rdata = 8'h18;
        @(negedge clk); ce_n = 1; oe_n = 1;
        // R7: read ending exactly when busy rises, then new period
        @(negedge clk); ce_n = 0; oe_n = 0;
        @(negedge clk); ce_n = 1; oe_n = 1; eng_busy = 1;
        host_read(8'h00, 1);
        host_read(8'h00, 1);
        load(1'b0);
        host_read(8'h00, 2);
        @(negedge clk); eng_busy = 0;
        cyc(2);
        // R5: erase busy period
        @(negedge clk); eng_busy = 1; eng_erase = 1;
        for (int k = 0; k < 4; k++) host_read(8'hC3, 1 + k);
        @(negedge clk); eng_busy = 0; eng_erase = 0;
        host_read(8'hE7, 2);
        // R10: reset mid busy period clears toggle and poll bit
        @(negedge clk); eng_busy = 1;
        host_read(8'h00, 1);
        @(negedge clk); rst = 1;
        cyc(2);
        @(negedge clk); rst = 0;
        host_read(8'h00, 1);
        @(negedge clk); eng_busy = 0;
        cyc(3);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule